// File: doc/BRIEF.md
# Fractional-Divisor Baud Rate Generator

This block sets the sampling cadence of a serial transmitter and receiver. The module clock first passes through an optional divide-by-four prescaler. A programmable divider then divides the prescaled clock by a value with a 16-bit integer part and a 4-bit fractional part in sixteenths. The divider emits a one-clock sample enable at 16 or 8 times the serial bit rate. A second output marks each bit boundary: it fires on every 16th sample enable, or on every 8th in the faster oversampling mode.

A 4-bit phase accumulator produces the fraction. At the end of each sample period the fractional code is added to the accumulator. When that sum carries, the next period is one prescaled clock longer. Any 16 consecutive periods therefore hold exactly F extra prescaled clocks. The divisor registers are loaded one byte at a time through a shared write-data bus and three write strobes. They have no reset value, so software must write them before it uses the outputs. Each write restarts the timing from a clean phase. In 8x mode with an odd fractional code, successive bit times may differ by half a prescaled clock on either side of the mean. This is expected behaviour.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, `sample_en` and `bit_en` are low.
- R2: With fractional code 0, prescaler off and integer divisor N≥1, consecutive `sample_en` pulses are exactly N clocks apart.
- R3: With integer divisor N≥1 and fractional code F, every sample period lasts N or N+1 prescaled clocks. Any 16 consecutive periods, excluding the first period after a divisor write, total exactly 16·N+F prescaled clocks.
- R4: When `pre_div4` is 1, every sample period is four times the length it has when `pre_div4` is 0.
- R5: An integer divisor of 0 is treated as 1, so no sample period is shorter than one prescaled clock.
- R6: On a fractional-divisor write only `wr_data[3:0]` is stored. Bits 7:4 are ignored.
- R7: `bit_en` is high only together with `sample_en`. After a divisor write it fires on every 16th `sample_en` when `os8_mode` is 0, and on every 8th when `os8_mode` is 1.
- R8: A write to any divisor register clears the counter, the phase accumulator, the prescaler and the bit counter. The first `sample_en` then appears N×(1 or 4) clocks after the write edge, and that first period is never stretched.
- R9: With `os8_mode`=1 and an odd F, each bit period lasts 8·N+⌊F/2⌋ or 8·N+⌈F/2⌉ prescaled clocks. Two consecutive bit periods together last 16·N+F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_div4 | input | 1 | 1 selects divide-by-four prescaling of `clk` |
| os8_mode | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| wr_div_lo | input | 1 | Write strobe for integer divisor bits 7:0 |
| wr_div_hi | input | 1 | Write strobe for integer divisor bits 15:8 |
| wr_frac | input | 1 | Write strobe for the fractional divisor (low 4 bits) |
| wr_data | input | 8 | Write data shared by the three strobes |
| sample_en | output | 1 | One-clock oversampling enable |
| bit_en | output | 1 | One-clock bit-boundary enable, coincident with `sample_en` |

## Verification
Assertions check several properties on every cycle:
- the period counter stays below the current period length;
- a stretched period occurs only when the fractional code is nonzero;
- in divide-by-four mode the prescaler never ticks on two adjacent clocks;
- every write leaves the datapath cleared with no enable on the following cycle;
- `bit_en` never appears without `sample_en`.

Only the bench scenarios can show the rate itself. This covers the exact 16-period sums for the fraction, the fourfold stretch from the prescaler, the zero-integer clamp, the position of `bit_en` among the sample pulses, and the two bit lengths allowed in 8x mode with an odd code.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int BYTE_W   = 8;
    localparam int INT_W    = 2 * BYTE_W;
    localparam int FRAC_W   = 4;
    localparam int CNT_W    = INT_W + 1;
    localparam int PRE_RATIO = 4;
    localparam int OS_SLOW  = 16;
    localparam int OS_FAST  = 8;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } divisor_t;

    typedef struct packed {
        logic              carry;
        logic [FRAC_W-1:0] phase;
    } phase_step_t;

    // Integer part clamped so that a period is never zero long.
    function automatic logic [CNT_W-1:0] eff_int(input logic [INT_W-1:0] ip);
        return (ip == '0) ? CNT_W'(1) : {1'b0, ip};
    endfunction

    function automatic phase_step_t advance_phase(input logic [FRAC_W-1:0] ph,
                                                  input logic [FRAC_W-1:0] f);
        logic [FRAC_W:0] s;
        s = {1'b0, ph} + {1'b0, f};
        return phase_step_t'(s);
    endfunction
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
    parameter int RATIO = brg_pkg::PRE_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic div_en,
    output logic tick
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (div_en) begin
            pcnt <= (pcnt == LAST) ? '0 : pcnt + PW'(1);
        end else begin
            pcnt <= '0;
        end
    end

    assign tick = div_en ? (pcnt == LAST) : 1'b1;

    // R4: with division active the prescaled clock never ticks twice in a row
    assert_pre_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (div_en && $past(div_en) && $past(tick) && !$past(clr)) |-> !tick);
endmodule

// File: rtl/brg_divider.sv
module brg_divider
    import brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_frac,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              clr,
    output logic              done
);
    divisor_t          div_q;
    logic [CNT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic              long_q;
    logic [CNT_W-1:0]  period;
    phase_step_t       nxt;

    assign clr = wr_lo | wr_hi | wr_frac;

    // Divisor registers: deliberately no reset value.
    always_ff @(posedge clk) begin
        if (wr_lo)   div_q.ipart[BYTE_W-1:0]     <= wr_byte;
        if (wr_hi)   div_q.ipart[INT_W-1:BYTE_W] <= wr_byte;
        if (wr_frac) div_q.fpart                 <= wr_byte[FRAC_W-1:0];
    end

    assign period = eff_int(div_q.ipart) + CNT_W'(long_q);
    assign nxt    = advance_phase(acc, div_q.fpart);
    assign done   = tick && !clr && ((cnt + CNT_W'(1)) == period);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            acc    <= '0;
            long_q <= 1'b0;
        end else if (tick) begin
            if (done) begin
                cnt    <= '0;
                acc    <= nxt.phase;
                long_q <= nxt.carry;
            end else begin
                cnt    <= cnt + CNT_W'(1);
            end
        end
    end

    // R3: the period count never reaches the current period length
    assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < period);
    // R3: a stretched period needs a nonzero fractional code
    assert_stretch_needs_frac_R3: assert property (@(posedge clk) disable iff (rst)
        long_q |-> (div_q.fpart != '0));
    // R8: any divisor write restarts from a clean phase
    assert_write_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && acc == '0 && !long_q));
endmodule

// File: rtl/brg_bitcount.sv
module brg_bitcount #(
    parameter int SLOW = brg_pkg::OS_SLOW,
    parameter int FAST = brg_pkg::OS_FAST
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fast,
    input  logic pulse,
    output logic bit_pulse
);
    localparam int BW = $clog2(SLOW);
    localparam logic [BW-1:0] LAST_SLOW = BW'(SLOW - 1);
    localparam logic [BW-1:0] LAST_FAST = BW'(FAST - 1);

    logic [BW-1:0] bcnt;
    logic [BW-1:0] last;

    assign last      = fast ? LAST_FAST : LAST_SLOW;
    assign bit_pulse = pulse && (bcnt >= last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bcnt <= '0;
        end else if (pulse) begin
            bcnt <= bit_pulse ? '0 : bcnt + BW'(1);
        end
    end

    // R7: a bit boundary restarts the sample count
    assert_bit_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_pulse && !clr) |=> (bcnt == '0));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_div4,
    input  logic              os8_mode,
    input  logic              wr_div_lo,
    input  logic              wr_div_hi,
    input  logic              wr_frac,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              sample_en,
    output logic              bit_en
);
    logic tick;
    logic clr;
    logic done;
    logic bit_pulse;

    brg_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_lo   (wr_div_lo),
        .wr_hi   (wr_div_hi),
        .wr_frac (wr_frac),
        .wr_byte (wr_data),
        .clr     (clr),
        .done    (done)
    );

    brg_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .div_en (pre_div4),
        .tick   (tick)
    );

    brg_bitcount #(.SLOW(OS_SLOW), .FAST(OS_FAST)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .fast      (os8_mode),
        .pulse     (done),
        .bit_pulse (bit_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sample_en <= 1'b0;
            bit_en    <= 1'b0;
        end else begin
            sample_en <= done;
            bit_en    <= bit_pulse;
        end
    end

    // R7: a bit boundary always lands on a sample enable
    assert_bit_on_sample_R7: assert property (@(posedge clk) disable iff (rst)
        bit_en |-> sample_en);
    // R8: no enable in the cycle after a divisor write
    assert_quiet_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_div_lo || wr_div_hi || wr_frac) |=> (!sample_en && !bit_en));
    // R6: a fraction write with upper bits set still restarts cleanly
    assert_frac_upper_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_frac && (wr_data[BYTE_W-1:FRAC_W] != '0)) |=> !sample_en);
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_div4 = 1'b0;
    logic       os8_mode = 1'b0;
    logic       wr_div_lo = 1'b0;
    logic       wr_div_hi = 1'b0;
    logic       wr_frac = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sample_en;
    logic       bit_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst(rst), .pre_div4(pre_div4), .os8_mode(os8_mode),
        .wr_div_lo(wr_div_lo), .wr_div_hi(wr_div_hi), .wr_frac(wr_frac),
        .wr_data(wr_data), .sample_en(sample_en), .bit_en(bit_en)
    );

    // Vector: {integer[15:0], fraction byte[7:0], 6'b0, pre_div4, os8}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {16'd1,   8'h00, 6'd0, 1'b0, 1'b0},
        {16'd5,   8'h00, 6'd0, 1'b0, 1'b0},
        {16'd3,   8'hA5, 6'd0, 1'b0, 1'b0},
        {16'd2,   8'h0F, 6'd0, 1'b1, 1'b0},
        {16'd0,   8'h07, 6'd0, 1'b0, 1'b1},
        {16'd4,   8'h03, 6'd0, 1'b0, 1'b1},
        {16'd300, 8'h01, 6'd0, 1'b0, 1'b0},
        {16'd6,   8'h09, 6'd0, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_div_lo = (which == 0);
        wr_div_hi = (which == 1);
        wr_frac   = (which == 2);
        @(negedge clk);
        wr_div_lo = 1'b0;
        wr_div_hi = 1'b0;
        wr_frac   = 1'b0;
    endtask

    task automatic next_pulse(output int gap, output bit b);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!sample_en && gap < 400000);
        b = bit_en;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int gaps [32];
        bit bits [32];

        // R1: outputs held low during reset
        repeat (3) @(negedge clk);
        check(!sample_en && !bit_en, "R1 reset", int'({sample_en, bit_en}), 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            int n, eff, f, pre, m, s16, viol, bviol;
            bit b;
            n    = int'(VEC[v][31:16]);
            f    = int'(VEC[v][11:8]);
            eff  = (n == 0) ? 1 : n;
            pre  = VEC[v][1] ? 4 : 1;
            m    = VEC[v][0] ? 8 : 16;
            pre_div4 = VEC[v][1];
            os8_mode = VEC[v][0];
            wr(1, VEC[v][31:24]);
            wr(0, VEC[v][23:16]);
            wr(2, VEC[v][15:8]);
            for (int k = 0; k < 32; k++) next_pulse(gaps[k], bits[k]);

            // R8 first period after write; R5 when n==0
            check(gaps[0] == eff * pre, (n == 0) ? "R5 R8 first period" : "R8 first period",
                  gaps[0], eff * pre);

            viol = 0;
            for (int k = 0; k < 32; k++)
                if (gaps[k] != eff * pre && gaps[k] != (eff + 1) * pre) viol++;
            check(viol == 0, "R3 per-period bound", viol, 0);

            s16 = 0;
            for (int k = 1; k <= 16; k++) s16 += gaps[k];
            // R2 (F=0), R3, R4 (pre_div4), R6 (upper bits A in vector 2)
            check(s16 == (16 * eff + f) * pre,
                  (v == 2) ? "R6 R3 sum16" : (pre == 4) ? "R4 R3 sum16" :
                  (f == 0) ? "R2 sum16" : "R3 sum16",
                  s16, (16 * eff + f) * pre);

            bviol = 0;
            for (int k = 0; k < 32; k++)
                if (bits[k] != (((k + 1) % m) == 0)) bviol++;
            check(bviol == 0, "R7 bit_en placement", bviol, 0);

            if (m == 8 && (f % 2) == 1) begin
                int b1, b2, lo, hi;
                b1 = 0; b2 = 0;
                for (int k = 8; k < 16; k++)  b1 += gaps[k];
                for (int k = 16; k < 24; k++) b2 += gaps[k];
                lo = (8 * eff + f / 2) * pre;
                hi = (8 * eff + (f + 1) / 2) * pre;
                check((b1 == lo || b1 == hi) && (b2 == lo || b2 == hi),
                      "R9 bit jitter", b1, lo);
                check(b1 + b2 == (16 * eff + f) * pre, "R9 bit pair", b1 + b2,
                      (16 * eff + f) * pre);
            end
            b = 1'b0;
        end

        // R2 with prescaler off, period N exactly, directed
        pre_div4 = 1'b0;
        os8_mode = 1'b0;
        wr(1, 8'h00);
        wr(0, 8'd7);
        wr(2, 8'h00);
        begin
            int g;
            bit b;
            next_pulse(g, b);
            next_pulse(g, b);
            check(g == 7, "R2 integer period", g, 7);
            // R8: mid-run write restarts timing
            repeat (3) @(negedge clk);
            wr(0, 8'd9);
            next_pulse(g, b);
            check(g == 9, "R8 restart after rewrite", g, 9);
        end

        // R1: reset mid-run forces outputs low
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!sample_en && !bit_en, "R1 mid-run reset", int'({sample_en, bit_en}), 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule